// File: doc/BRIEF.md
# Serial Result Port

This block holds a single 20-bit conversion result and hands it to a host over a three-wire read interface. The conversion side offers a new word with a one-cycle request; the port opens a two-cycle update window (its ready flag is forced high), then either loads the word or drops it. A word is dropped only while a host read session is in progress, and the drop sets a sticky overrun flag.

A host reads the held word by pulling its select low and toggling the serial clock. Both host signals are asynchronous. They pass through two-flop synchronisers in the master clock domain, so the serial clock must be slow compared with the master clock. Once the select is recognised, the data output is enabled with the most significant bit already driven. The first rising serial clock edge arms the shifter. Each later falling edge moves to the next bit. The falling edge after the last bit releases the output and empties the port. Releasing the select mid-word keeps the current bit until the next falling edge, and the held word remains available for another read.

Top module: `res_serial_port`

## Requirements
- R1: A request taken while no window is open sets `ready_n` high for the two cycles after the request edge; the load-or-drop decision happens on the second edge after it.
- R2: At the decision, the word is loaded when the port is empty or no read session is active; a load makes `ready_n` low and replaces the held word.
- R3: A word offered while a read session is active is dropped, the held word is kept, and `ovr` goes high and stays high until the next load clears it.
- R4: With a word held, no window open and `cs_n_in` low, `sdo_oe` rises within three clock edges and `sdo` carries bit 19 of the word.
- R5: A falling serial clock edge seen before the first rising edge of a session does not advance `sdo`.
- R6: After arming, each falling serial clock edge moves `sdo` to the next lower bit, so the 20 bits come out MSB first.
- R7: The falling edge after bit 0 drops `sdo_oe`, empties the port and sets `ready_n` high.
- R8: If `cs_n_in` rises after arming, `sdo` keeps its bit until the next falling edge and then `sdo_oe` falls. If it rises before arming, `sdo_oe` falls at once. In both cases the word stays held and the next selection starts again at bit 19.
- R9: A low `cs_n_in` is not recognised while the update window is open; selection begins only after the decision.
- R10: A request that arrives while a window is already open is ignored.
- R11: After reset, `ready_n` is high and `sdo_oe` and `ovr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req | input | 1 | One-cycle request to offer a new result word |
| upd_word | input | 20 | Result word that goes with the request |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| cs_n_in | input | 1 | Host select, active low, asynchronous |
| ready_n | output | 1 | Low while an unread word is held and no window is open |
| sdo | output | 1 | Serial data, meaningful when `sdo_oe` is high |
| sdo_oe | output | 1 | Output enable of the serial data driver |
| ovr | output | 1 | Sticky overrun flag, set when a word is dropped |

## Verification
A request sampled at edge e makes `ready_n` high after e and after e+1, and the decision shows on the outputs after e+2. The bench samples on the three falling clock edges that follow the request to cover these points. A change on `sclk_in` or `cs_n_in` passes through two synchroniser flops and one state register, so its effect appears three edges later. The bench drives each host signal on a falling clock edge and samples four cycles later, which keeps every check clear of the edge where the result changes. The window checks are the exception to this settle time: there `cs_n_in` is sampled on the exact cycles when it must still be ignored.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_WAIT = 2'd1,
    SH_RUN  = 2'd2,
    SH_STOP = 2'd3
  } sh_state_e;

  // The new word may replace the held one when nothing is held or no read is running.
  function automatic logic may_accept(input logic held, input logic reading);
    return !held || !reading;
  endfunction

  // The shifter counts as armed once a rising serial clock edge has been seen in a session.
  function automatic logic is_armed(input sh_state_e st);
    return (st == SH_RUN) || (st == SH_STOP);
  endfunction

endpackage

// File: rtl/rsp_sync.sv
module rsp_sync #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= INIT;
          else        chain[0] <= async_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= INIT;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign lvl = chain[STAGES-1];
endmodule

// File: rtl/rsp_loader.sv
module rsp_loader
  import rsp_pkg::*;
#(
  parameter int W       = 20,
  parameter int WIN_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_req,
  input  logic [W-1:0] upd_word,
  input  logic         reading,
  input  logic         done_evt,
  output logic [W-1:0] word_q,
  output logic         word_full,
  output logic         win_act,
  output logic         load_evt,
  output logic         drop_evt,
  output logic         ovr
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] win_cnt;
  logic [W-1:0]  pend_q;
  logic          decide;

  assign win_act  = (win_cnt != '0);
  assign decide   = (win_cnt == CW'(1));
  assign load_evt = decide && may_accept(word_full, reading);
  assign drop_evt = decide && !may_accept(word_full, reading);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      pend_q  <= '0;
    end else if (!win_act && upd_req) begin
      win_cnt <= CW'(WIN_CYC);
      pend_q  <= upd_word;
    end else if (win_act) begin
      win_cnt <= win_cnt - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q    <= '0;
      word_full <= 1'b0;
    end else if (load_evt) begin
      word_q    <= pend_q;
      word_full <= 1'b1;
    end else if (done_evt) begin
      word_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovr <= 1'b0;
    else if (load_evt) ovr <= 1'b0;
    else if (drop_evt) ovr <= 1'b1;
  end
endmodule

// File: rtl/rsp_shifter.sv
module rsp_shifter
  import rsp_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] word_q,
  input  logic         word_full,
  input  logic         win_act,
  input  logic         cs_lvl,
  input  logic         sclk_lvl,
  output logic         sel,
  output logic         armed,
  output logic         sclk_fall,
  output logic         done_evt,
  output logic         sdo,
  output logic         sdo_oe
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

  sh_state_e     st;
  logic [IW-1:0] idx;
  logic          sclk_prev;
  logic          sclk_rise;
  logic          start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sclk_prev <= 1'b0;
    else        sclk_prev <= sclk_lvl;

  assign sclk_rise = sclk_lvl && !sclk_prev;
  assign sclk_fall = !sclk_lvl && sclk_prev;
  assign start     = (st == SH_IDLE) && word_full && !win_act && !cs_lvl;
  assign done_evt  = (st == SH_RUN) && sclk_fall && !cs_lvl && (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SH_IDLE;
      idx <= TOP_IDX;
    end else begin
      unique case (st)
        SH_IDLE: if (start) begin
          st  <= SH_WAIT;
          idx <= TOP_IDX;
        end
        SH_WAIT: begin
          if (cs_lvl)         st <= SH_IDLE;
          else if (sclk_rise) st <= SH_RUN;
        end
        SH_RUN: begin
          if (sclk_fall) begin
            if (cs_lvl || idx == '0) st <= SH_IDLE;
            else                     idx <= idx - IW'(1);
          end else if (cs_lvl) begin
            st <= SH_STOP;
          end
        end
        SH_STOP: if (sclk_fall) st <= SH_IDLE;
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign sel    = (st != SH_IDLE);
  assign armed  = is_armed(st);
  assign sdo_oe = sel;
  assign sdo    = sel ? word_q[idx] : 1'b0;
endmodule

// File: rtl/res_serial_port.sv
module res_serial_port #(
  parameter int W       = 20,
  parameter int WIN_CYC = 2,
  parameter int SYNC_N  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_req,
  input  logic [W-1:0] upd_word,
  input  logic         sclk_in,
  input  logic         cs_n_in,
  output logic         ready_n,
  output logic         sdo,
  output logic         sdo_oe,
  output logic         ovr
);
  logic         cs_lvl;
  logic         sclk_lvl;
  logic [W-1:0] word_q;
  logic         word_full;
  logic         win_act;
  logic         load_evt;
  logic         drop_evt;
  logic         done_evt;
  logic         sh_sel;
  logic         sh_armed;
  logic         sclk_fall;

  rsp_sync #(.STAGES(SYNC_N), .INIT(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cs_n_in), .lvl(cs_lvl)
  );

  rsp_sync #(.STAGES(SYNC_N), .INIT(1'b0)) u_sclk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sclk_in), .lvl(sclk_lvl)
  );

  rsp_loader #(.W(W), .WIN_CYC(WIN_CYC)) u_loader (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_word(upd_word),
    .reading(sh_sel), .done_evt(done_evt), .word_q(word_q),
    .word_full(word_full), .win_act(win_act), .load_evt(load_evt),
    .drop_evt(drop_evt), .ovr(ovr)
  );

  rsp_shifter #(.W(W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .word_q(word_q), .word_full(word_full),
    .win_act(win_act), .cs_lvl(cs_lvl), .sclk_lvl(sclk_lvl),
    .sel(sh_sel), .armed(sh_armed), .sclk_fall(sclk_fall),
    .done_evt(done_evt), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  assign ready_n = !word_full || win_act;
endmodule

// File: rtl/res_serial_port_chk.sv
module res_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic ready_n,
  input logic sdo,
  input logic sdo_oe,
  input logic ovr,
  input logic word_full,
  input logic win_act,
  input logic load_evt,
  input logic drop_evt,
  input logic done_evt,
  input logic sh_sel,
  input logic sh_armed,
  input logic sclk_fall,
  input logic cs_lvl
);
  AST_DECIDE_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt || drop_evt) |-> (win_act && $past(win_act))); // R1
  AST_LOAD_LOWERS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !ready_n); // R2
  AST_DROP_ONLY_READING: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> (sh_sel && word_full)); // R3
  AST_OVR_CLEARED_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !ovr); // R3
  AST_DRIVE_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> word_full); // R4
  AST_FALL_BEFORE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_sel && !sh_armed && sclk_fall && !cs_lvl) |=> (sdo_oe && $stable(sdo))); // R5
  AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (ready_n && !sdo_oe)); // R7
  AST_NO_SELECT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (win_act && !sh_sel) |=> !sdo_oe); // R9
endmodule

bind res_serial_port res_serial_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready_n(ready_n), .sdo(sdo), .sdo_oe(sdo_oe),
  .ovr(ovr), .word_full(word_full), .win_act(win_act), .load_evt(load_evt),
  .drop_evt(drop_evt), .done_evt(done_evt), .sh_sel(sh_sel),
  .sh_armed(sh_armed), .sclk_fall(sclk_fall), .cs_lvl(cs_lvl)
);

// File: tb/res_serial_port_tb.sv
module res_serial_port_tb;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         upd_req = 1'b0;
  logic [W-1:0] upd_word = '0;
  logic         sclk_in = 1'b0;
  logic         cs_n_in = 1'b1;
  logic         ready_n, sdo, sdo_oe, ovr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  res_serial_port u_dut (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_word(upd_word),
    .sclk_in(sclk_in), .cs_n_in(cs_n_in), .ready_n(ready_n), .sdo(sdo),
    .sdo_oe(sdo_oe), .ovr(ovr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Offer a word; checks the window shape and the outcome on the three following samples.
  task automatic offer(input logic [W-1:0] w, input logic exp_ready_after);
    upd_req  = 1'b1;
    upd_word = w;
    @(negedge clk);
    upd_req = 1'b0;
    check("R1 window cycle 1", 32'(ready_n), 32'd1);
    @(negedge clk);
    check("R1 window cycle 2", 32'(ready_n), 32'd1);
    @(negedge clk);
    check("R1/R2 after decision", 32'(ready_n), 32'(exp_ready_after));
  endtask

  task automatic sclk_pulse();
    sclk_in = 1'b1; idle(4);
    sclk_in = 1'b0; idle(4);
  endtask

  // Session already selected with sclk low: collect all bits.
  task automatic read_bits(output logic [W-1:0] got);
    for (int i = W - 1; i >= 0; i--) begin
      got[i] = sdo;
      sclk_pulse();
    end
  endtask

  task automatic t_reset();
    check("R11 ready_n at reset", 32'(ready_n), 32'd1);
    check("R11 sdo_oe at reset", 32'(sdo_oe), 32'd0);
    check("R11 ovr at reset", 32'(ovr), 32'd0);
  endtask

  task automatic t_full_read();
    logic [W-1:0] a, got;
    a = 20'hA5C3E;
    offer(a, 1'b0);
    sclk_in = 1'b1; idle(4);
    cs_n_in = 1'b0; idle(4);
    check("R4 enable after select", 32'(sdo_oe), 32'd1);
    check("R4 msb driven", 32'(sdo), 32'(a[W-1]));
    sclk_in = 1'b0; idle(4);
    check("R5 fall before arm keeps msb", 32'(sdo), 32'(a[W-1]));
    check("R5 still enabled", 32'(sdo_oe), 32'd1);
    read_bits(got);
    check("R6 word msb first", 32'(got), 32'(a));
    check("R7 released after lsb", 32'(sdo_oe), 32'd0);
    check("R7 ready_n high when empty", 32'(ready_n), 32'd1);
    cs_n_in = 1'b1; idle(4);
  endtask

  task automatic t_cs_release();
    logic [W-1:0] b, got;
    b = 20'h6D2B1;
    offer(b, 1'b0);
    cs_n_in = 1'b0; idle(4);
    for (int k = 0; k < 5; k++) sclk_pulse();
    check("R6 bit after five falls", 32'(sdo), 32'(b[W-6]));
    sclk_in = 1'b1; idle(4);
    cs_n_in = 1'b1; idle(4);
    check("R8 bit held after release", 32'(sdo), 32'(b[W-6]));
    check("R8 still driving", 32'(sdo_oe), 32'd1);
    sclk_in = 1'b0; idle(4);
    check("R8 high-Z after fall", 32'(sdo_oe), 32'd0);
    check("R8 word kept", 32'(ready_n), 32'd0);
    cs_n_in = 1'b0; idle(4);
    check("R8 reselect restarts at msb", 32'(sdo), 32'(b[W-1]));
    cs_n_in = 1'b1; idle(4);
    check("R8 unarmed release immediate", 32'(sdo_oe), 32'd0);
    cs_n_in = 1'b0; idle(4);
    read_bits(got);
    check("R8 full word after restarts", 32'(got), 32'(b));
    cs_n_in = 1'b1; idle(4);
  endtask

  task automatic t_overrun();
    logic [W-1:0] c, d, e, got;
    c = 20'h1F0E4; d = 20'hE0B7A; e = 20'h5A5A5;
    offer(c, 1'b0);
    cs_n_in = 1'b0; idle(4);
    offer(d, 1'b0);
    check("R3 overrun set", 32'(ovr), 32'd1);
    read_bits(got);
    check("R3 held word kept", 32'(got), 32'(c));
    check("R3 overrun sticky", 32'(ovr), 32'd1);
    cs_n_in = 1'b1; idle(4);
    offer(d, 1'b0);
    check("R3 overrun cleared by load", 32'(ovr), 32'd0);
    offer(e, 1'b0);
    check("R2 deselected overwrite no overrun", 32'(ovr), 32'd0);
    cs_n_in = 1'b0; idle(4);
    read_bits(got);
    check("R2 overwritten word read", 32'(got), 32'(e));
    cs_n_in = 1'b1; idle(4);
  endtask

  task automatic t_window_select();
    logic [W-1:0] f, g, got;
    f = 20'h3C96F; g = 20'hC3690;
    upd_req = 1'b1; upd_word = f; cs_n_in = 1'b0;
    @(negedge clk);
    upd_word = g;
    @(negedge clk);
    upd_req = 1'b0;
    check("R9 not selected in window", 32'(sdo_oe), 32'd0);
    @(negedge clk);
    check("R9 not selected at decision", 32'(sdo_oe), 32'd0);
    idle(4);
    check("R9 selected after load", 32'(sdo_oe), 32'd1);
    read_bits(got);
    check("R10 second request ignored", 32'(got), 32'(f));
    cs_n_in = 1'b1; idle(4);
    check("R10 no stray load", 32'(ready_n), 32'd1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(3);
    t_full_read();
    t_cs_release();
    t_overrun();
    t_window_select();
    finish_run();
  end
endmodule